// File: doc/BRIEF.md
# Gigabit reduced-pin DDR Ethernet interface shim

This block sits between a MAC that works on whole bytes and a PHY that uses the reduced-pin RGMII interface. On the transmit side it takes one byte per cycle of a 125 MHz clock (8 ns period), with an enable flag and an error flag. It sends the byte over four data pins as two nibbles, one in each half of the clock cycle. The control pin is also double-data-rate: the first half carries the enable, and the second half carries enable XOR error. The shim also drives a forwarded transmit clock that trails the launch clock by a quarter period, which gives the PHY about 2 ns of setup on every edge.

The falling-half launch is clocked by a supplied 180-degree copy of the interface clock. The quarter-shifted forwarding is clocked by a supplied 90-degree copy. A clock-generator lock input holds the transmit pins idle until the clocks are good. On receive, the shim samples the four data pins and the control pin on both edges of the PHY's receive clock. It rebuilds the byte and decodes the valid and error flags from the two control samples.

Top module: `rgmii_ddr_shim`

## Requirements
- R1: While `rst_n` is low, `rgmii_txd`, `rgmii_tx_ctl`, `rgmii_txc`, `rx_data`, `rx_dv` and `rx_er` are all zero, whatever the inputs are.
- R2: A byte sampled at a rising edge of `clk` appears on `rgmii_txd` as bits 3:0 while `clk` is high after that edge, then as bits 7:4 from the following rising edge of `clk180` until the next rising edge of `clk`.
- R3: In the same two halves, `rgmii_tx_ctl` carries `tx_en` first and then `tx_en ^ tx_er`.
- R4: When `clk_locked` is low at a rising edge of `clk`, both halves of that cycle drive zero on `rgmii_txd` and `rgmii_tx_ctl`. From the next rising edge of `clk90`, `rgmii_txc` stays low.
- R5: While locked and out of reset, `rgmii_txc` goes high at each rising edge of `clk90` and low half a period later. It is therefore low at every rising edge of `clk` and high at every rising edge of `clk180`.
- R6: Receive data sampled on a rising edge of `rx_clk` becomes `rx_data[3:0]`. The data sampled on the following falling edge becomes `rx_data[7:4]`. The rebuilt byte appears at the next rising edge of `rx_clk`.
- R7: Along with that byte, `rx_dv` equals the rising-edge control sample, and `rx_er` equals the XOR of the rising-edge and falling-edge control samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz transmit launch clock |
| clk90 | input | 1 | Copy of `clk` shifted by a quarter period |
| clk180 | input | 1 | Copy of `clk` shifted by half a period, used for falling-half launch |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_locked | input | 1 | Clock generator lock indication, synchronous to `clk` |
| tx_data | input | 8 | Transmit byte |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error |
| rgmii_txd | output | 4 | DDR transmit data pins |
| rgmii_tx_ctl | output | 1 | DDR transmit control pin |
| rgmii_txc | output | 1 | Forwarded transmit clock |
| rx_clk | input | 1 | Receive clock from the PHY |
| rgmii_rxd | input | 4 | DDR receive data pins |
| rgmii_rx_ctl | input | 1 | DDR receive control pin |
| rx_data | output | 8 | Rebuilt receive byte |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |

## Verification
The transmit assertions assume three things about the clocks. First, `clk180` is the exact inverse of `clk`. Second, `clk90` trails `clk` by less than half a period. Third, `clk_locked` changes only between edges of `clk`. The bench derives `clk180` by inversion, makes `clk90` a 2 ns delayed copy, and changes every input 1 ns after an edge.

The receive assertions assume that the pins stay stable around each `rx_clk` edge. The bench runs `rx_clk` offset from `clk` and changes the receive pins 2 ns after an edge, well inside each half period. It also holds the receive control pin low during reset, so the first decoded flags after reset are clean.

// File: rtl/rgmii_pkg.sv
package rgmii_pkg;
  localparam int NIBBLE_W = 4;
  localparam int BYTE_W   = 2 * NIBBLE_W;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [NIBBLE_W-1:0] nib;
    logic                ctl;
  } ddr_half_t;
endpackage

// File: rtl/rgmii_rst_sync.sv
module rgmii_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rgmii_ddr_out.sv
module rgmii_ddr_out #(
  parameter int W = 1
) (
  input  logic         clk_lead,
  input  logic         clk_trail,
  input  logic         rst_n,
  input  logic [W-1:0] d_lead,
  input  logic [W-1:0] d_trail,
  output logic [W-1:0] q
);
  // Two flops on separate clocks; XOR of both shows whichever was written last.
  logic [W-1:0] lead_q, trail_q;

  always_ff @(posedge clk_lead or negedge rst_n) begin
    if (!rst_n) lead_q <= '0;
    else        lead_q <= d_lead ^ trail_q;
  end

  always_ff @(posedge clk_trail or negedge rst_n) begin
    if (!rst_n) trail_q <= '0;
    else        trail_q <= d_trail ^ lead_q;
  end

  assign q = lead_q ^ trail_q;
endmodule

// File: rtl/rgmii_tx_path.sv
module rgmii_tx_path
  import rgmii_pkg::*;
#(
  parameter int NIB_W = NIBBLE_W
) (
  input  logic             clk,
  input  logic             clk90,
  input  logic             clk180,
  input  logic             rst_n,
  input  logic             locked,
  input  logic [2*NIB_W-1:0] tx_data,
  input  logic             tx_en,
  input  logic             tx_er,
  output logic [NIB_W-1:0] txd,
  output logic             tx_ctl,
  output logic             txc
);
  logic [NIB_W-1:0] first_nib, hold_nib_d, hold_nib_q;
  logic             first_ctl, hold_ctl_d, hold_ctl_q;
  logic             run_q;
  logic             clk90_n;

  always_comb begin
    first_nib  = '0;
    first_ctl  = 1'b0;
    hold_nib_d = '0;
    hold_ctl_d = 1'b0;
    if (locked) begin
      first_nib  = tx_data[NIB_W-1:0];
      first_ctl  = tx_en;
      hold_nib_d = tx_data[2*NIB_W-1:NIB_W];
      hold_ctl_d = tx_en ^ tx_er;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_nib_q <= '0;
      hold_ctl_q <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      hold_nib_q <= hold_nib_d;
      hold_ctl_q <= hold_ctl_d;
      run_q      <= locked;
    end
  end

  assign clk90_n = ~clk90;

  rgmii_ddr_out #(.W(NIB_W + 1)) u_data_ddr (
    .clk_lead (clk),
    .clk_trail(clk180),
    .rst_n    (rst_n),
    .d_lead   ({first_ctl, first_nib}),
    .d_trail  ({hold_ctl_q, hold_nib_q}),
    .q        ({tx_ctl, txd})
  );

  rgmii_ddr_out #(.W(1)) u_clk_fwd (
    .clk_lead (clk90),
    .clk_trail(clk90_n),
    .rst_n    (rst_n),
    .d_lead   (run_q),
    .d_trail  (1'b0),
    .q        (txc)
  );

  AST_TX_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> (txd == '0 && tx_ctl == 1'b0)); // R4
  AST_TXC_LOW_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    txc == 1'b0); // R5
  AST_TXC_HIGH_MID_CYCLE: assert property (@(posedge clk180) disable iff (!rst_n)
    txc == run_q); // R5
endmodule

// File: rtl/rgmii_rx_path.sv
module rgmii_rx_path
  import rgmii_pkg::*;
#(
  parameter int NIB_W = NIBBLE_W
) (
  input  logic               rx_clk,
  input  logic               rst_n,
  input  logic [NIB_W-1:0]   rxd,
  input  logic               rx_ctl,
  output logic [2*NIB_W-1:0] rx_data,
  output logic               rx_dv,
  output logic               rx_er
);
  ddr_half_t rise_q, fall_q;
  logic [2*NIB_W-1:0] data_d;
  logic               dv_d, er_d;

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= '{nib: rxd, ctl: rx_ctl};
  end

  always_ff @(negedge rx_clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= '{nib: rxd, ctl: rx_ctl};
  end

  always_comb begin
    data_d = {fall_q.nib, rise_q.nib};
    dv_d   = rise_q.ctl;
    er_d   = rise_q.ctl ^ fall_q.ctl;
  end

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_dv   <= 1'b0;
      rx_er   <= 1'b0;
    end else begin
      rx_data <= data_d;
      rx_dv   <= dv_d;
      rx_er   <= er_d;
    end
  end

  // Cycles since reset, so the checks below never look back past it.
  logic [1:0] primed_q;
  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) primed_q <= '0;
    else        primed_q <= {primed_q[0], 1'b1};
  end

  AST_RX_DV_FROM_RISE: assert property (@(posedge rx_clk) disable iff (!rst_n)
    primed_q[1] |-> rx_dv == $past(rx_ctl, 2)); // R7
  AST_RX_ER_FROM_EDGES: assert property (@(posedge rx_clk) disable iff (!rst_n)
    primed_q[1] |-> rx_er == ($past(rx_ctl, 2) ^ $past(fall_q.ctl))); // R7
  AST_RX_LOW_NIBBLE: assert property (@(posedge rx_clk) disable iff (!rst_n)
    primed_q[1] |-> rx_data[NIB_W-1:0] == $past(rxd, 2)); // R6
endmodule

// File: rtl/rgmii_ddr_shim.sv
module rgmii_ddr_shim
  import rgmii_pkg::*;
(
  input  logic                clk,
  input  logic                clk90,
  input  logic                clk180,
  input  logic                rst_n,
  input  logic                clk_locked,
  input  logic [BYTE_W-1:0]   tx_data,
  input  logic                tx_en,
  input  logic                tx_er,
  output logic [NIBBLE_W-1:0] rgmii_txd,
  output logic                rgmii_tx_ctl,
  output logic                rgmii_txc,
  input  logic                rx_clk,
  input  logic [NIBBLE_W-1:0] rgmii_rxd,
  input  logic                rgmii_rx_ctl,
  output logic [BYTE_W-1:0]   rx_data,
  output logic                rx_dv,
  output logic                rx_er
);
  logic tx_rst_n, rx_rst_n;

  rgmii_rst_sync #(.STAGES(SYNC_STAGES)) u_tx_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(tx_rst_n)
  );

  rgmii_rst_sync #(.STAGES(SYNC_STAGES)) u_rx_rst (
    .clk(rx_clk), .arst_n(rst_n), .srst_n(rx_rst_n)
  );

  rgmii_tx_path #(.NIB_W(NIBBLE_W)) u_tx (
    .clk    (clk),
    .clk90  (clk90),
    .clk180 (clk180),
    .rst_n  (tx_rst_n),
    .locked (clk_locked),
    .tx_data(tx_data),
    .tx_en  (tx_en),
    .tx_er  (tx_er),
    .txd    (rgmii_txd),
    .tx_ctl (rgmii_tx_ctl),
    .txc    (rgmii_txc)
  );

  rgmii_rx_path #(.NIB_W(NIBBLE_W)) u_rx (
    .rx_clk (rx_clk),
    .rst_n  (rx_rst_n),
    .rxd    (rgmii_rxd),
    .rx_ctl (rgmii_rx_ctl),
    .rx_data(rx_data),
    .rx_dv  (rx_dv),
    .rx_er  (rx_er)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (rgmii_txd == '0 && rgmii_tx_ctl == 1'b0 && rgmii_txc == 1'b0)); // R1
endmodule

// File: tb/rgmii_ddr_shim_test.sv
`timescale 1ns/1ps
module rgmii_ddr_shim_test;
  localparam int CLK_PERIOD = 8;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int QTR  = CLK_PERIOD / 4;

  logic       clk, clk90, clk180, rst_n, clk_locked;
  logic [7:0] tx_data;
  logic       tx_en, tx_er;
  logic [3:0] rgmii_txd;
  logic       rgmii_tx_ctl, rgmii_txc;
  logic       rx_clk;
  logic [3:0] rgmii_rxd;
  logic       rgmii_rx_ctl;
  logic [7:0] rx_data;
  logic       rx_dv, rx_er;

  int n_checks = 0;
  int n_fails  = 0;

  rgmii_ddr_shim uut (
    .clk(clk), .clk90(clk90), .clk180(clk180), .rst_n(rst_n),
    .clk_locked(clk_locked), .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er),
    .rgmii_txd(rgmii_txd), .rgmii_tx_ctl(rgmii_tx_ctl), .rgmii_txc(rgmii_txc),
    .rx_clk(rx_clk), .rgmii_rxd(rgmii_rxd), .rgmii_rx_ctl(rgmii_rx_ctl),
    .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  initial begin
    clk = 1'b0;
    forever #(HALF) clk = ~clk;
  end
  assign clk180 = ~clk;
  assign #(QTR) clk90 = clk;

  initial begin
    rx_clk = 1'b0;
    #1;
    forever #(HALF) rx_clk = ~rx_clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // R1: everything quiet while reset is held, even with active inputs
  task automatic t_reset();
    rst_n = 1'b0; clk_locked = 1'b1;
    tx_data = 8'hA5; tx_en = 1'b1; tx_er = 1'b1;
    rgmii_rxd = 4'h0; rgmii_rx_ctl = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    check("R1 txd",  {28'd0, rgmii_txd}, 32'd0);
    check("R1 ctl",  {31'd0, rgmii_tx_ctl}, 32'd0);
    check("R1 txc",  {31'd0, rgmii_txc}, 32'd0);
    check("R1 rx",   {22'd0, rx_er, rx_dv, rx_data}, 32'd0);
    tx_en = 1'b0; tx_er = 1'b0; tx_data = 8'h00;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // R2, R3, R5: one byte out over both halves, forwarded clock phase
  task automatic t_tx_byte(input logic [7:0] d, input logic en, input logic er);
    @(posedge clk); #1;
    tx_data = d; tx_en = en; tx_er = er;
    @(posedge clk);
    #(QTR);
    check("R2 low nibble", {28'd0, rgmii_txd}, {28'd0, d[3:0]});
    check("R3 ctl first half", {31'd0, rgmii_tx_ctl}, {31'd0, en});
    #1;
    check("R5 txc high", {31'd0, rgmii_txc}, 32'd1);
    #(HALF - 1);
    check("R2 high nibble", {28'd0, rgmii_txd}, {28'd0, d[7:4]});
    check("R3 ctl second half", {31'd0, rgmii_tx_ctl}, {31'd0, en ^ er});
    #1;
    check("R5 txc low", {31'd0, rgmii_txc}, 32'd0);
  endtask

  // R4: lock lost while a frame is active
  task automatic t_unlocked();
    @(posedge clk); #1;
    tx_data = 8'hFF; tx_en = 1'b1; tx_er = 1'b0; clk_locked = 1'b0;
    @(posedge clk);
    #1;
    check("R4 txd first half", {28'd0, rgmii_txd}, 32'd0);
    check("R4 ctl first half", {31'd0, rgmii_tx_ctl}, 32'd0);
    #(HALF);
    check("R4 txd second half", {28'd0, rgmii_txd}, 32'd0);
    check("R4 ctl second half", {31'd0, rgmii_tx_ctl}, 32'd0);
    @(posedge clk); #(QTR + 1);
    check("R4 txc held low", {31'd0, rgmii_txc}, 32'd0);
    #(HALF);
    check("R4 txc still low", {31'd0, rgmii_txc}, 32'd0);
    clk_locked = 1'b1; tx_en = 1'b0; tx_data = 8'h00;
    repeat (2) @(posedge clk);
  endtask

  // R6, R7: one byte in over both edges of rx_clk
  task automatic t_rx_byte(input logic [7:0] d, input logic dv, input logic er);
    @(posedge rx_clk);
    #2;
    rgmii_rxd = d[3:0]; rgmii_rx_ctl = dv;
    #(CLK_PERIOD);
    rgmii_rxd = d[7:4]; rgmii_rx_ctl = dv ^ er;
    #(CLK_PERIOD);
    check("R6 rx byte", {24'd0, rx_data}, {24'd0, d});
    check("R7 rx_dv", {31'd0, rx_dv}, {31'd0, dv});
    check("R7 rx_er", {31'd0, rx_er}, {31'd0, er});
    rgmii_rxd = 4'h0; rgmii_rx_ctl = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_tx_byte(8'hA5, 1'b1, 1'b0);
    t_tx_byte(8'h3C, 1'b1, 1'b1);
    t_tx_byte(8'hF0, 1'b0, 1'b1);
    t_tx_byte(8'h0F, 1'b0, 1'b0);
    t_unlocked();
    t_tx_byte(8'h69, 1'b1, 1'b0);
    t_rx_byte(8'h5A, 1'b1, 1'b0);
    t_rx_byte(8'hC3, 1'b1, 1'b1);
    t_rx_byte(8'h81, 1'b0, 1'b1);
    t_rx_byte(8'h7E, 1'b0, 1'b0);
    report();
  end
endmodule